// File: doc/BRIEF.md
# Resonant Capacitor Tuning Controller

This block trims the switchable capacitor bank of a receive LC tank so that the tank resonates near the carrier. The bank has a group of base units and a group of trial units. A tuning run connects a chosen number of base units. It then offers each trial unit once, in ascending order. Before a trial unit is switched in, the controller opens the track phase of an external track-and-latch comparator so that the comparator holds the present rectified supply. After the unit has been switched in and a programmable settling wait has passed, the controller fires the latch strobe. It reads back one bit that says whether the supply rose.

A trial unit that raises the supply stays connected. Any other trial unit is disconnected again. Once every trial unit has been tested, the controller drops its busy flag, pulses done for one cycle and holds the final capacitance count. Every unit has the same value, so the count is the tuning code.

Top module: `cap_tune_ctrl`

## Requirements
- R1: After reset, busy and done are 0 and no strobe is active. The lowest DEF_RST base units are enabled and no trial unit is. code equals DEF_RST.
- R2: A start accepted while idle loads the base count from def_count and clears all trial units. cap_en bits [count-1:0] are then 1 and the other base bits are 0.
- R3: Each trial begins with cmp_track high for exactly one cycle while the trial unit is still off. From the next cycle the enabled-unit count is one higher. cmp_track and cmp_latch are never high together.
- R4: cmp_latch is a single-cycle pulse. It rises settle_cycles+2 cycles after the rise of cmp_track in the same trial.
- R5: cmp_up is sampled in the cycle after the latch strobe. If it is 1, the trial unit stays enabled. If it is 0, the unit is disabled from the next cycle on.
- R6: Trial unit k sits at cap_en bit N_BASE+k. Units are tried in the order k = 0 to N_TRIAL-1. Each unit is tried exactly once, so a run makes exactly N_TRIAL latch strobes.
- R7: done is high for exactly one cycle, in the first cycle with busy low after a run. While idle with no start, code and cap_en do not change.
- R8: A start asserted while busy is ignored. The run continues unchanged, and no strobe occurs while idle.
- R9: A def_count above N_BASE is clamped to N_BASE.
- R10: code equals the base count plus the number of kept trial units. It therefore matches a greedy search that adds one unit per step whenever the supply strictly rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a tuning run (ignored while busy) |
| def_count | input | CW | Starting number of base units |
| settle_cycles | input | SETTLE_W | Extra settling cycles after a unit switches |
| cmp_up | input | 1 | Comparator result: supply rose since track |
| cap_en | output | N_BASE+N_TRIAL | Unit capacitor enables; base units low, trial units high |
| cmp_track | output | 1 | Comparator track phase |
| cmp_latch | output | 1 | Comparator latch strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| code | output | CW | Number of enabled units |

## Verification
Runs are made against a behavioural supply curve indexed by unit count. A parabola with a random peak tells a correct stop at the resonance apart from overshoot. A random curve with local bumps separates true per-step keep-or-drop from any search that looks ahead. A flat curve shows that a tie drops the unit, and a rising curve shows that every unit is kept. Directed runs vary the settling wait (0 and maximum), clamp an oversized default and pulse start mid-run, which checks the strobe timing, the clamp and that start is ignored while busy.

// File: rtl/tune_pkg.sv
package tune_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TRACK,
      ST_SETTLE,
      ST_LATCH,
      ST_DECIDE
   } tune_st_e;
endpackage

// File: rtl/tune_fsm.sv
module tune_fsm
   import tune_pkg::*;
#(
   parameter int N_TRIAL  = 7,
   parameter int SETTLE_W = 8,
   parameter int TW       = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic                cmp_up,
   output logic                load,
   output logic                set_unit,
   output logic                clr_unit,
   output logic [TW-1:0]       idx,
   output logic                cmp_track,
   output logic                cmp_latch,
   output logic                busy,
   output logic                done
);
   tune_st_e            st;
   logic [SETTLE_W-1:0] cnt;
   logic                last;

   assign last      = (idx == TW'(N_TRIAL - 1));
   assign load      = (st == ST_IDLE) && start;
   assign set_unit  = (st == ST_TRACK);
   assign clr_unit  = (st == ST_DECIDE) && !cmp_up;
   assign cmp_track = (st == ST_TRACK);
   assign cmp_latch = (st == ST_LATCH);
   assign busy      = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         idx  <= '0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  idx <= '0;
                  st  <= ST_TRACK;
               end
            end
            ST_TRACK: begin
               cnt <= settle_cycles;
               st  <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (cnt == '0) st <= ST_LATCH;
               else           cnt <= cnt - 1'b1;
            end
            ST_LATCH: st <= ST_DECIDE;
            ST_DECIDE: begin
               if (last) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= ST_TRACK;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R4: the settle counter never runs past its loaded value
   p_settle_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SETTLE && cnt != '0) |=> (st == ST_SETTLE && cnt == $past(cnt) - 1'b1));
   // R6: trial index stays inside the trial group
   p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx <= TW'(N_TRIAL - 1)));
endmodule

// File: rtl/tune_bank.sv
module tune_bank #(
   parameter int N_BASE  = 8,
   parameter int N_TRIAL = 7,
   parameter int CW      = 4,
   parameter int TW      = 3,
   parameter int DEF_RST = 4,
   localparam int N_BANK = N_BASE + N_TRIAL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CW-1:0]     def_count,
   input  logic              set_unit,
   input  logic              clr_unit,
   input  logic [TW-1:0]     idx,
   output logic [N_BANK-1:0] cap_en,
   output logic [CW-1:0]     code
);
   logic [CW-1:0]      base_q;
   logic [N_TRIAL-1:0] mask;
   logic [CW-1:0]      kept;
   logic [CW-1:0]      def_clamped;

   assign def_clamped = (def_count > CW'(N_BASE)) ? CW'(N_BASE) : def_count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= CW'(DEF_RST);
         mask   <= '0;
      end else if (load) begin
         base_q <= def_clamped;
         mask   <= '0;
      end else begin
         for (int j = 0; j < N_TRIAL; j++) begin
            if (idx == TW'(j)) begin
               if (set_unit)      mask[j] <= 1'b1;
               else if (clr_unit) mask[j] <= 1'b0;
            end
         end
      end
   end

   for (genvar i = 0; i < N_BASE; i++) begin : g_base
      assign cap_en[i] = (base_q > CW'(i));
   end
   for (genvar j = 0; j < N_TRIAL; j++) begin : g_trial
      assign cap_en[N_BASE + j] = mask[j];
   end

   always_comb begin
      kept = '0;
      for (int j = 0; j < N_TRIAL; j++) kept = kept + CW'(mask[j]);
   end
   assign code = base_q + kept;

   // R9: base count never exceeds the base group
   p_base_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      base_q <= CW'(N_BASE));
   // R2: a load empties the trial group
   p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cap_en[N_BANK-1:N_BASE] == '0));
endmodule

// File: rtl/cap_tune_ctrl.sv
module cap_tune_ctrl #(
   parameter int N_BASE      = 8,
   parameter int N_TRIAL     = 7,
   parameter int SETTLE_W    = 8,
   parameter int DEF_RST     = 4,
   parameter int MAX_RUN_CYC = 20000,
   localparam int N_BANK = N_BASE + N_TRIAL,
   localparam int CW     = $clog2(N_BANK + 1),
   localparam int TW     = (N_TRIAL > 1) ? $clog2(N_TRIAL) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CW-1:0]       def_count,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic                cmp_up,
   output logic [N_BANK-1:0]   cap_en,
   output logic                cmp_track,
   output logic                cmp_latch,
   output logic                busy,
   output logic                done,
   output logic [CW-1:0]       code
);
   if (N_BASE < 1 || N_TRIAL < 1) begin : g_bad_size
      $error("cap_tune_ctrl: N_BASE and N_TRIAL must be at least 1");
   end
   if (DEF_RST < 0 || DEF_RST > N_BASE) begin : g_bad_def
      $error("cap_tune_ctrl: DEF_RST outside base group");
   end
   if (N_TRIAL * ((1 << SETTLE_W) + 3) > MAX_RUN_CYC) begin : g_bad_time
      $error("cap_tune_ctrl: worst-case run exceeds MAX_RUN_CYC");
   end

   logic          load, set_unit, clr_unit;
   logic [TW-1:0] idx;

   tune_fsm #(.N_TRIAL(N_TRIAL), .SETTLE_W(SETTLE_W), .TW(TW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
      .cmp_up(cmp_up), .load(load), .set_unit(set_unit), .clr_unit(clr_unit),
      .idx(idx), .cmp_track(cmp_track), .cmp_latch(cmp_latch),
      .busy(busy), .done(done)
   );

   tune_bank #(.N_BASE(N_BASE), .N_TRIAL(N_TRIAL), .CW(CW), .TW(TW), .DEF_RST(DEF_RST)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(load), .def_count(def_count),
      .set_unit(set_unit), .clr_unit(clr_unit), .idx(idx),
      .cap_en(cap_en), .code(code)
   );

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(code) && $stable(cap_en)));
   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmp_track && cmp_latch));
   p_track_unit_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_track |=> ($countones(cap_en) == $past($countones(cap_en)) + 1));
   p_latch_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_latch |=> !cmp_latch);
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!cmp_track && !cmp_latch));
   p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmp_latch) && !cmp_up) |=> ($countones(cap_en) == $past($countones(cap_en)) - 1));
endmodule

// File: tb/tb_cap_tune_ctrl.sv
`timescale 1ns/1ps
module tb_cap_tune_ctrl;
   localparam int N_BASE = 8, N_TRIAL = 7, SETTLE_W = 8, DEF_RST = 4;
   localparam int N_BANK = N_BASE + N_TRIAL;
   localparam int CW = $clog2(N_BANK + 1);

   logic clk = 0, rst_n = 0, start = 0, cmp_up = 0;
   logic [CW-1:0] def_count = '0;
   logic [SETTLE_W-1:0] settle_cycles = '0;
   logic [N_BANK-1:0] cap_en;
   logic cmp_track, cmp_latch, busy, done;
   logic [CW-1:0] code;

   int checks = 0, fails = 0;
   int vtab [0:N_BANK];
   int ref_v = 0;
   longint cyc = 0;
   longint t_track = 0;
   int strobes = 0, trial_no = 0, cur_settle = 0;
   bit after_track = 0, finished = 0;

   cap_tune_ctrl #(.N_BASE(N_BASE), .N_TRIAL(N_TRIAL), .SETTLE_W(SETTLE_W), .DEF_RST(DEF_RST)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .def_count(def_count),
      .settle_cycles(settle_cycles), .cmp_up(cmp_up), .cap_en(cap_en),
      .cmp_track(cmp_track), .cmp_latch(cmp_latch), .busy(busy), .done(done), .code(code)
   );

   always #2.5 clk = ~clk;

   function automatic int pop(input logic [N_BANK-1:0] v);
      int n = 0;
      for (int i = 0; i < N_BANK; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural track-and-latch comparator on the supply curve
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cmp_track) ref_v <= vtab[pop(cap_en)];
      if (cmp_latch) cmp_up <= (vtab[pop(cap_en)] > ref_v);
   end

   // per-trial monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (after_track) begin
            check(cap_en[N_BASE + trial_no] == 1'b1, "R3/R6 trial unit on", cap_en[N_BASE + trial_no], 1);
            after_track = 0;
            trial_no++;
         end
         if (cmp_track) begin
            check(cap_en[N_BASE + trial_no] == 1'b0, "R3 unit off during track", cap_en[N_BASE + trial_no], 0);
            t_track = cyc;
            after_track = 1;
         end
         if (cmp_latch) begin
            strobes++;
            check(cyc - t_track == longint'(cur_settle + 2), "R4 latch timing", cyc - t_track, cur_settle + 2);
         end
      end
   end

   task automatic fill(input int mode);
      int pk;
      pk = int'($urandom_range(N_BANK, 0));
      for (int n = 0; n <= N_BANK; n++) begin
         case (mode)
            0: vtab[n] = 5000 - 20 * (n - pk) * (n - pk);
            1: vtab[n] = int'($urandom_range(1000, 0));
            2: vtab[n] = 777;
            default: vtab[n] = 100 * n;
         endcase
      end
   endtask

   task automatic run(input int def, input int s, input bit poke);
      int c, nw;
      logic [N_BANK-1:0] exp_en;
      c = (def > N_BASE) ? N_BASE : def;
      exp_en = '0;
      for (int i = 0; i < c; i++) exp_en[i] = 1'b1;
      for (int k = 0; k < N_TRIAL; k++) begin
         if (vtab[c + 1] > vtab[c]) begin
            c++;
            exp_en[N_BASE + k] = 1'b1;
         end
      end
      @(negedge clk);
      def_count = CW'(def);
      settle_cycles = SETTLE_W'(s);
      cur_settle = s;
      strobes = 0;
      trial_no = 0;
      start = 1;
      @(negedge clk);
      start = 0;
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      nw = (def > N_BASE) ? N_BASE : def;
      check(pop(cap_en) == nw, "R2/R9 base load", pop(cap_en), nw);
      if (poke) begin
         repeat (s + 4) @(negedge clk);
         def_count = CW'(0);
         start = 1;
         @(negedge clk);
         start = 0;
      end
      while (!done) @(negedge clk);
      check(busy == 1'b0, "R7 idle with done", busy, 0);
      check(code == CW'(c), "R10 final code", code, c);
      check(cap_en == exp_en, "R5/R2 kept units", cap_en, exp_en);
      check(strobes == N_TRIAL, "R6 strobe count", strobes, N_TRIAL);
      @(negedge clk);
      check(done == 1'b0, "R7 done single cycle", done, 0);
      repeat (3) @(negedge clk);
      check(code == CW'(c) && cap_en == exp_en, "R7 code held idle", code, c);
   endtask

   initial begin
      #(200000 * 5);
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      fill(3);
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && cmp_track == 0 && cmp_latch == 0, "R1 reset flags", busy, 0);
      check(code == CW'(DEF_RST), "R1 reset code", code, DEF_RST);
      check(cap_en == N_BANK'((1 << DEF_RST) - 1), "R1 reset enables", cap_en, (1 << DEF_RST) - 1);
      rst_n = 1;
      // directed corners
      fill(2); run(3, 0, 0);                 // flat: tie drops every unit (R5)
      fill(3); run(2, 255, 0);               // rising: all kept, max settle (R4)
      fill(3); run(13, 1, 0);                // oversized default clamps (R9)
      fill(0); run(5, 3, 1);                 // start while busy ignored (R8)
      fill(1); run(0, 0, 0);
      // random curves
      for (int t = 0; t < 30; t++) begin
         fill(int'($urandom_range(1, 0)));
         run(int'($urandom_range(N_BASE + 2, 0)), int'($urandom_range(20, 0)), bit'($urandom_range(1, 0)));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule